// File: doc/BRIEF.md
# Two-Tier Prioritized Event Controller

This block decides which event a processor core services next. Sixteen event levels are numbered 0 to 15, and a lower number always wins. Fixed request lines feed the top levels: emulation (0), reset (1), nonmaskable interrupt (2), synchronous exception (3), hardware error (5) and core timer (6). Level 4 is a reserved hole. The nine general levels 7 to 15 take their requests from two places. Peripheral sources arrive through a programmable routing table that places each source on one of levels 7 to 13. Software can also raise any general level directly; levels 14 and 15 are meant for this.

Every level keeps a pending latch. Each clock, the controller looks at the pending levels that are enabled and picks the highest-priority one. It takes that level only when the level outranks the one the core is servicing now, which lets handlers nest. A take emits a one-cycle strobe carrying the level number, which also serves as the vector-entry index. At the same time it stores the supplied return address in that level's own register. A return-from-event pulse retires the level being serviced, and the active level falls back to the next one still in service.

Top module: `evc_top`

## Requirements
- R1: After reset no level is pending or active, `take` and `act_vld` are low, every routing entry selects level 7, and every enable bit is 0.
- R2: Among the pending, enabled levels the one with the lowest number is taken, and `take_lvl` carries that number.
- R3: Levels 0 to 3 are taken whatever the enable register holds. Level 4 is never taken.
- R4: Enable bit n (value of `en_val[n]` captured on `en_wr`, n from 5 to 15) gates level n. A disabled level stays pending and is taken once it is enabled. Bits 0 to 4 of `en_val` have no effect.
- R5: A `map_wr` assigns source `map_sel` to level `map_lvl` only when `map_lvl` is from 7 to 13. Other values leave the entry as it was. Sources that share a level are OR-ed together.
- R6: `swi_set` marks level `swi_lvl` pending when `swi_lvl` is from 7 to 15. Smaller values have no effect.
- R7: A level is taken only when no level is active or its number is lower than `act_lvl`. `take` is high for exactly one cycle per take.
- R8: A request seen at one rising edge becomes pending there. The take decision is made at the next rising edge, and `take` is high in the cycle after that edge.
- R9: On a take, `ret_addr` is stored in the taken level's register. `rd_addr` shows the register selected by `rd_lvl`, and all registers read 0 after reset.
- R10: `rfe` clears the active bit of the current level, so `act_lvl` falls back to the next active level or `act_vld` drops. No take happens in a cycle where `rfe` is high.
- R11: Taking a level clears its pending bit, so a single request pulse is serviced only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| emu_req | input | 1 | Emulation request, level 0 |
| rst_req | input | 1 | Reset event request, level 1 |
| nmi_req | input | 1 | Nonmaskable interrupt, level 2 |
| exc_req | input | 1 | Synchronous exception, level 3 |
| hwe_req | input | 1 | Hardware error, level 5 |
| tmr_req | input | 1 | Core timer, level 6 |
| src_req | input | NSRC | Peripheral requests |
| map_wr | input | 1 | Write a routing entry |
| map_sel | input | SW | Source selected for the write |
| map_lvl | input | 4 | Target level for the write |
| en_wr | input | 1 | Write the enable register |
| en_val | input | 16 | Enable bits by level |
| swi_set | input | 1 | Software raise |
| swi_lvl | input | 4 | Level to raise |
| ret_addr | input | AW | Return address to capture |
| rfe | input | 1 | Return from current event |
| rd_lvl | input | 4 | Return register selector |
| rd_addr | output | AW | Selected return address |
| take | output | 1 | Event-taken strobe |
| take_lvl | output | 4 | Taken level, which is also the vector index |
| act_vld | output | 1 | Some level in service |
| act_lvl | output | 4 | Highest-priority level in service |

## Verification
The hardest state to reach is deep nesting with a backlog. Several levels must be active at once while lower-priority requests wait, a return must unwind to exactly the right level, and the backlog must then drain in order. Directed sequences build this case: an NMI is pulsed together with an exception, then a software raise of level 4 and of a disabled level 14 is added. The sequences check that only the right level preempts, and that each return releases the next one in line. A long random phase then mixes peripheral requests, remaps, enable writes and returns. Every cycle it compares the outputs against a behavioural model.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int NLVL    = 16;
  localparam int LW      = 4;
  localparam int RSVD    = 4;
  localparam int MASK_LO = 5;
  localparam int GEN_LO  = 7;
  localparam int PERI_HI = 13;
  localparam int GEN_HI  = 15;

  // lowest set index wins
  function automatic logic [LW-1:0] low_idx(input logic [NLVL-1:0] v);
    low_idx = '0;
    for (int i = NLVL - 1; i >= 0; i--)
      if (v[i]) low_idx = LW'(i);
  endfunction
endpackage

// File: rtl/evc_pick.sv
module evc_pick
  import evc_pkg::*;
(
  input  logic [NLVL-1:0] vec,
  output logic            vld,
  output logic [LW-1:0]   idx
);
  always_comb begin
    vld = |vec;
    idx = low_idx(vec);
  end
endmodule

// File: rtl/evc_route.sv
module evc_route
  import evc_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_core_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            map_wr,
  input  logic [SW-1:0]   map_sel,
  input  logic [LW-1:0]   map_lvl,
  output logic [NLVL-1:0] lvl_set
);
  logic [LW-1:0] route_q [NSRC];
  logic          lvl_ok;

  assign lvl_ok = (map_lvl >= LW'(GEN_LO)) && (map_lvl <= LW'(PERI_HI));

  for (genvar s = 0; s < NSRC; s++) begin : g_entry
    logic          wr_en;
    logic [LW-1:0] route_d;
    assign wr_en = map_wr && lvl_ok && (map_sel == SW'(s));
    always_comb begin
      route_d = route_q[s];
      if (wr_en) route_d = map_lvl;
    end
    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n) route_q[s] <= LW'(GEN_LO);
      else             route_q[s] <= route_d;
    end
  end

  always_comb begin
    lvl_set = '0;
    for (int s = 0; s < NSRC; s++)
      if (src_req[s]) lvl_set[route_q[s]] = 1'b1;
  end
endmodule

// File: rtl/evc_top.sv
module evc_top
  import evc_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int AW   = 32,
  localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            emu_req,
  input  logic            rst_req,
  input  logic            nmi_req,
  input  logic            exc_req,
  input  logic            hwe_req,
  input  logic            tmr_req,
  input  logic [NSRC-1:0] src_req,
  input  logic            map_wr,
  input  logic [SW-1:0]   map_sel,
  input  logic [3:0]      map_lvl,
  input  logic            en_wr,
  input  logic [15:0]     en_val,
  input  logic            swi_set,
  input  logic [3:0]      swi_lvl,
  input  logic [AW-1:0]   ret_addr,
  input  logic            rfe,
  input  logic [3:0]      rd_lvl,
  output logic [AW-1:0]   rd_addr,
  output logic            take,
  output logic [3:0]      take_lvl,
  output logic            act_vld,
  output logic [3:0]      act_lvl
);
  // reset synchronizer: async assert, sync release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [NLVL-1:0]         pend_q, pend_d, act_q, act_d, set_vec, route_set;
  logic [NLVL-1:0]         en_eff, elig, take_oh, ret_oh;
  logic [NLVL-1:MASK_LO]   en_q, en_d;
  logic                    cand_vld, cur_vld, do_take, do_ret;
  logic [LW-1:0]           cand_idx, cur_idx;
  logic                    take_q;
  logic [LW-1:0]           take_lvl_q;
  logic [AW-1:0]           ret_q [NLVL];

  evc_route #(.NSRC(NSRC)) u_route (
    .clk(clk), .rst_core_n(rst_core_n), .src_req(src_req),
    .map_wr(map_wr), .map_sel(map_sel), .map_lvl(map_lvl), .lvl_set(route_set)
  );

  evc_pick u_pick_cand (.vec(elig),  .vld(cand_vld), .idx(cand_idx));
  evc_pick u_pick_cur  (.vec(act_q), .vld(cur_vld),  .idx(cur_idx));

  // request collection
  always_comb begin
    set_vec    = route_set;
    set_vec[0] = emu_req;
    set_vec[1] = rst_req;
    set_vec[2] = nmi_req;
    set_vec[3] = exc_req;
    set_vec[RSVD] = 1'b0;
    set_vec[5] = hwe_req;
    set_vec[6] = tmr_req;
    if (swi_set && (swi_lvl >= LW'(GEN_LO))) set_vec[swi_lvl] = 1'b1;
  end

  always_comb begin
    en_eff       = {en_q, 5'b00000};
    en_eff[3:0]  = 4'b1111;
    elig         = pend_q & en_eff;
    do_take      = !rfe && cand_vld && (!cur_vld || (cand_idx < cur_idx));
    do_ret       = rfe && cur_vld;
    take_oh      = do_take ? (NLVL'(1) << cand_idx) : '0;
    ret_oh       = do_ret  ? (NLVL'(1) << cur_idx)  : '0;
    pend_d       = (pend_q & ~take_oh) | set_vec;
    act_d        = (act_q & ~ret_oh) | take_oh;
    en_d         = en_wr ? en_val[NLVL-1:MASK_LO] : en_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pend_q     <= '0;
      act_q      <= '0;
      en_q       <= '0;
      take_q     <= 1'b0;
      take_lvl_q <= '0;
    end else begin
      pend_q     <= pend_d;
      act_q      <= act_d;
      en_q       <= en_d;
      take_q     <= do_take;
      take_lvl_q <= do_take ? cand_idx : take_lvl_q;
    end
  end

  for (genvar l = 0; l < NLVL; l++) begin : g_ret
    logic          cap_en;
    logic [AW-1:0] ret_d;
    assign cap_en = take_oh[l];
    always_comb begin
      ret_d = ret_q[l];
      if (cap_en) ret_d = ret_addr;
    end
    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n) ret_q[l] <= '0;
      else             ret_q[l] <= ret_d;
    end
  end

  assign rd_addr  = ret_q[rd_lvl];
  assign take     = take_q;
  assign take_lvl = take_lvl_q;
  assign act_vld  = cur_vld;
  assign act_lvl  = cur_idx;
endmodule

// File: rtl/evc_chk.sv
module evc_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rfe,
  input logic          take,
  input logic [3:0]    take_lvl,
  input logic          act_vld,
  input logic [3:0]    act_lvl,
  input logic [3:0]    rd_lvl,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] ret_addr
);
  p_take_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (act_vld && act_lvl == take_lvl));

  p_no_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (take_lvl != 4'd4));

  p_rfe_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rfe |=> !take);

  p_preempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && $past(act_vld)) |-> (take_lvl < $past(act_lvl)));

  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rd_lvl == take_lvl) |-> (rd_addr == $past(ret_addr)));

  p_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !(take && take_lvl == $past(take_lvl)));
endmodule

bind evc_top evc_chk #(.AW(AW)) u_evc_chk (.*);

// File: tb/test_evc_top.sv
module test_evc_top;
  localparam int NSRC = 8;
  localparam int AW   = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic emu_req = 0, rst_req = 0, nmi_req = 0, exc_req = 0, hwe_req = 0, tmr_req = 0;
  logic [NSRC-1:0] src_req = '0;
  logic map_wr = 0;
  logic [2:0] map_sel = '0;
  logic [3:0] map_lvl = '0;
  logic en_wr = 0;
  logic [15:0] en_val = '0;
  logic swi_set = 0;
  logic [3:0] swi_lvl = '0;
  logic [AW-1:0] ret_addr = '0;
  logic rfe = 0;
  logic [3:0] rd_lvl = '0;
  logic [AW-1:0] rd_addr;
  logic take, act_vld;
  logic [3:0] take_lvl, act_lvl;

  int tests = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  evc_top #(.NSRC(NSRC), .AW(AW)) i_evc_top (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference model
  bit m_pend [16];
  bit m_act  [16];
  bit m_en   [16];
  int m_route [NSRC];
  logic [AW-1:0] m_ret [16];
  bit m_take;
  int m_tl;

  function automatic bit m_elig(int i);
    if (i < 4) return 1'b1;
    if (i == 4) return 1'b0;
    return m_en[i];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        m_pend[i] = 0; m_act[i] = 0; m_en[i] = 0; m_ret[i] = '0;
      end
      for (int s = 0; s < NSRC; s++) m_route[s] = 7;
      m_take = 0; m_tl = 0;
    end else begin
      bit setv [16];
      int cand, cur;
      cand = 16; cur = 16;
      for (int i = 0; i < 16; i++) setv[i] = 0;
      setv[0] = emu_req; setv[1] = rst_req; setv[2] = nmi_req;
      setv[3] = exc_req; setv[5] = hwe_req; setv[6] = tmr_req;
      for (int s = 0; s < NSRC; s++) if (src_req[s]) setv[m_route[s]] = 1;
      if (swi_set && swi_lvl >= 7) setv[swi_lvl] = 1;
      for (int i = 15; i >= 0; i--) begin
        if (m_pend[i] && m_elig(i)) cand = i;
        if (m_act[i]) cur = i;
      end
      m_take = 0;
      if (rfe) begin
        if (cur < 16) m_act[cur] = 0;
      end else if (cand < cur) begin
        m_act[cand] = 1; m_ret[cand] = ret_addr; m_take = 1; m_tl = cand; m_pend[cand] = 0;
      end
      for (int i = 0; i < 16; i++) if (setv[i]) m_pend[i] = 1;
      if (map_wr && map_lvl >= 7 && map_lvl <= 13) m_route[map_sel] = map_lvl;
      if (en_wr) for (int i = 5; i < 16; i++) m_en[i] = en_val[i];
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      int exp_lvl;
      exp_lvl = 0;
      for (int i = 15; i >= 0; i--) if (m_act[i]) exp_lvl = i;
      check(take == m_take, "R7 take", take, m_take);
      if (m_take) check(take_lvl == 4'(m_tl), "R2 take_lvl", take_lvl, m_tl);
      check(act_vld == (m_act.sum() with (int'(item)) != 0), "R10 act_vld", act_vld,
            m_act.sum() with (int'(item)));
      if (act_vld) check(act_lvl == 4'(exp_lvl), "R10 act_lvl", act_lvl, exp_lvl);
      check(rd_addr == m_ret[rd_lvl], "R9 rd_addr", rd_addr, m_ret[rd_lvl]);
    end
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // waits up to n cycles for a take; returns level or -1
  task automatic wait_take(input int n, output int lvl);
    lvl = -1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (take) begin lvl = take_lvl; return; end
    end
  endtask

  task automatic do_rfe;
    @(negedge clk); rfe = 1; @(negedge clk); rfe = 0;
  endtask

  int got;

  initial begin
    step(3);
    rst_n = 1;
    step(5);
    // R1 reset state
    check(take == 0, "R1 take", take, 0);
    check(act_vld == 0, "R1 act_vld", act_vld, 0);
    rd_lvl = 4'd9;
    step(1);
    check(rd_addr == 0, "R1 ret reg", rd_addr, 0);

    // R3/R2: NMI and exception together, nothing enabled
    ret_addr = 32'h100;
    nmi_req = 1; exc_req = 1;
    swi_set = 1; swi_lvl = 4'd4;   // R6 ignored level
    step(1);
    nmi_req = 0; exc_req = 0; swi_set = 0;
    wait_take(4, got);
    check(got == 2, "R2 NMI first", got, 2);
    step(3);
    check(take == 0, "R7 exception waits behind NMI", take, 0);
    check(act_lvl == 2, "R7 active stays 2", act_lvl, 2);
    do_rfe();
    wait_take(4, got);
    check(got == 3, "R3 exception unmaskable", got, 3);
    do_rfe();
    step(4);
    check(act_vld == 0, "R10 all retired", act_vld, 0);
    check(take == 0, "R11 no repeat take", take, 0);

    // R4: disabled software level stays pending
    swi_set = 1; swi_lvl = 4'd14; step(1); swi_set = 0;
    wait_take(6, got);
    check(got == -1, "R4 disabled level held", got, -1);
    en_wr = 1; en_val = 16'h4000; step(1); en_wr = 0;
    wait_take(4, got);
    check(got == 14, "R4 taken once enabled", got, 14);
    do_rfe();

    // R5: routing with an out-of-range write ignored
    en_wr = 1; en_val = 16'hFFFF; step(1); en_wr = 0;
    map_wr = 1; map_sel = 3'd3; map_lvl = 4'd9; step(1);
    map_lvl = 4'd15; step(1);
    map_wr = 0;
    ret_addr = 32'hABC0;
    src_req[3] = 1; step(1); src_req[3] = 0;
    wait_take(4, got);
    check(got == 9, "R5 routed to 9", got, 9);
    rd_lvl = 4'd9; step(1);
    check(rd_addr == 32'hABC0, "R9 captured address", rd_addr, 32'hABC0);
    do_rfe();

    // R8 timing: take exactly in the second cycle after the request
    @(negedge clk); tmr_req = 1;
    @(negedge clk); tmr_req = 0;
    check(take == 0, "R8 not yet", take, 0);
    @(negedge clk);
    check(take == 1 && take_lvl == 6, "R8 take on time", take_lvl, 6);
    do_rfe();
    step(3);

    // random phase, compared by the model every cycle
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      emu_req = ($urandom % 100) == 0;
      rst_req = ($urandom % 90) == 0;
      nmi_req = ($urandom % 60) == 0;
      exc_req = ($urandom % 40) == 0;
      hwe_req = ($urandom % 30) == 0;
      tmr_req = ($urandom % 25) == 0;
      src_req = NSRC'($urandom) & NSRC'($urandom) & NSRC'($urandom);
      map_wr  = ($urandom % 20) == 0;
      map_sel = 3'($urandom);
      map_lvl = 4'($urandom);
      en_wr   = ($urandom % 50) == 0;
      en_val  = 16'($urandom);
      swi_set = ($urandom % 15) == 0;
      swi_lvl = 4'($urandom);
      ret_addr = $urandom;
      rfe     = ($urandom % 4) == 0;
      rd_lvl  = 4'($urandom);
    end
    @(negedge clk);
    {emu_req, rst_req, nmi_req, exc_req, hwe_req, tmr_req, map_wr, en_wr, swi_set, rfe} = '0;
    src_req = '0;
    step(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule